// File: doc/BRIEF.md
# I2C Slave Address Recogniser and Status Flags

This block decides, one address byte at a time, whether an I2C slave is being called, and it keeps the byte-level status flags that a host processor reads and clears. A bit-level front end is assumed to exist. It delivers the received 7-bit calling address, the read/write bit and a strobe once the address byte has been shifted in. It also delivers a strobe at the end of every byte transfer, together with line-level indications: bus busy, lost arbitration, and the acknowledge bit that was received.

An address is accepted when any of the following holds:
- it equals the primary address;
- it equals a nonzero range address while range matching is enabled;
- it lies inside the inclusive window spanned by those two addresses while range matching is enabled;
- it is a general call (address 7'h00 with the write bit) while general-call recognition is enabled;
- it equals the second address while that match is enabled;
- it is the SMBus alert response address 7'h0C while alert response is enabled.

A small register bus gives the host three registers, selected by `host_addr`:
- **Control (0).** Writing it clears the addressed flag. Bit 4 selects transmit mode and bit 3 selects buffered mode.
- **Status (1).** Reads return the flags. Writes clear the write-one-to-clear flags.
- **Data (2).** Reads return the received byte. Writes load the byte to transmit.

A session state machine tracks the slave's role and drives the slave read/write indication. It has three states: SES_IDLE, SES_WRITE and SES_READ.
- **Address byte while the bus is busy.** A matching address moves the machine to SES_READ when the R/W bit is 1, or to SES_WRITE when it is 0. A non-matching address returns it to SES_IDLE.
- **Bus not busy.** The machine returns to SES_IDLE from any state, with priority over every other transition.
- **Otherwise.** The machine holds its state.

Top module: `i2c_slv_status`

## Requirements
- R1: After reset, the status register reads 8'h80 when bus busy and the received-NACK input are low; `addressed`, `slave_rw` and `irq` are 0. The status bits are: TCF bit 7, addressed bit 6, busy bit 5, arbitration lost bit 4, range hit bit 3, slave R/W bit 2, interrupt flag bit 1, received NACK bit 0.
- R2: An address strobe that matches the primary address makes `addressed`, `xfer_done` and `irq` 1 on the clock edge that samples the strobe. The flag is therefore visible one cycle after the strobe, before the acknowledge bit.
- R3: A calling address equal to the range address matches only when range matching is enabled and the range address is nonzero.
- R4: With range matching enabled and a nonzero range address, an address between min(primary, range) and max(primary, range) inclusive matches. Such an address also sets status bit 3, which is cleared by writing 1 to it.
- R5: Address 7'h00 with the R/W bit 0 matches only when general-call recognition is enabled.
- R6: The second address matches only when its enable is set. Address 7'h0C matches only when alert response is enabled.
- R7: An address strobe that matches no enabled source sets no flag.
- R8: Any write to the control register, whatever its value, clears `addressed`.
- R9: A byte-done strobe sets `xfer_done` and `irq`. With control bit 4 at 0, a data read clears `xfer_done` and a data write does not. With control bit 4 at 1, a data write clears it and a data read does not.
- R10: With control bit 3 at 1, a buffer-access strobe clears `xfer_done`. With control bit 3 at 0, the strobe has no effect.
- R11: Writing 1 to status bit 4, 3 or 1 clears that flag, and writing 0 leaves it unchanged. An arbitration-lost strobe sets bit 4. `irq` equals bit 1.
- R12: `slave_rw` equals the R/W bit of the last matched address while the bus stays busy. A non-matching address, or the bus going idle, brings it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Address byte received strobe |
| addr_in | input | 7 | Received calling address |
| addr_rw | input | 1 | R/W bit of the address byte |
| byte_done | input | 1 | Byte transfer complete strobe |
| buf_access | input | 1 | Internal data register access strobe (buffered mode) |
| bus_busy | input | 1 | Bus busy indication |
| arb_lost | input | 1 | Arbitration lost strobe |
| rx_nack | input | 1 | Acknowledge bit received was NACK |
| rx_data | input | 8 | Received data byte |
| cfg_prim_addr | input | 7 | Primary slave address |
| cfg_range_addr | input | 7 | Range address |
| cfg_range_en | input | 1 | Range matching enable |
| cfg_gc_en | input | 1 | General-call enable |
| cfg_alt_en | input | 1 | Second address enable |
| cfg_alt_addr | input | 7 | Second slave address |
| cfg_alert_en | input | 1 | Alert response enable |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write (1) or read (0) |
| host_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| tx_data | output | 8 | Byte loaded for transmission |
| addressed | output | 1 | Addressed-as-slave flag |
| xfer_done | output | 1 | Transfer-complete flag |
| slave_rw | output | 1 | Slave read/write indication |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, the local cause-and-effect rules:
- a primary hit raises the addressed flag, the transfer-complete flag and the interrupt on the following edge;
- a control write drops the addressed flag;
- a byte-done strobe raises the transfer-complete flag;
- a buffer-access strobe in buffered mode drops the transfer-complete flag;
- a one written to the arbitration bit drops it;
- an idle bus forces the read/write indication low.

Whether each address source is correctly gated, including the inclusive window when its bounds are reversed or equal and the zero range address, can only be shown by the bench. It sweeps every address with both R/W values across several configurations and compares against values computed arithmetically.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int unsigned HOST_AW = 2;

    localparam logic [HOST_AW-1:0] REG_CTRL = 2'd0;
    localparam logic [HOST_AW-1:0] REG_STAT = 2'd1;
    localparam logic [HOST_AW-1:0] REG_DATA = 2'd2;

    // status bit positions (host software decodes these)
    localparam int unsigned SB_TCF  = 7;
    localparam int unsigned SB_ADDR = 6;
    localparam int unsigned SB_BUSY = 5;
    localparam int unsigned SB_ARB  = 4;
    localparam int unsigned SB_RNG  = 3;
    localparam int unsigned SB_SRW  = 2;
    localparam int unsigned SB_INT  = 1;
    localparam int unsigned SB_NACK = 0;

    // control bit positions
    localparam int unsigned CB_TX  = 4;
    localparam int unsigned CB_BUF = 3;

    localparam logic [6:0] GCALL_ADDR = 7'h00;
    localparam logic [6:0] ALERT_ADDR = 7'h0C;

    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_WRITE = 2'd1,
        SES_READ  = 2'd2
    } session_e;

endpackage

// File: rtl/slv_addr_match.sv
module slv_addr_match
    import i2c_slv_pkg::*;
#(
    parameter int unsigned AW = 7
) (
    input  logic [AW-1:0] addr_in,
    input  logic          addr_rw,
    input  logic [AW-1:0] cfg_prim_addr,
    input  logic [AW-1:0] cfg_range_addr,
    input  logic          cfg_range_en,
    input  logic          cfg_gc_en,
    input  logic          cfg_alt_en,
    input  logic [AW-1:0] cfg_alt_addr,
    input  logic          cfg_alert_en,
    output logic          hit,
    output logic          range_hit
);

    localparam int unsigned N_SRC = 6;

    logic [AW-1:0]    lo_bound;
    logic [AW-1:0]    hi_bound;
    logic             range_ok;
    logic [N_SRC-1:0] src_hit;

    always_comb begin
        range_ok = cfg_range_en && (cfg_range_addr != '0);
        if (cfg_prim_addr <= cfg_range_addr) begin
            lo_bound = cfg_prim_addr;
            hi_bound = cfg_range_addr;
        end else begin
            lo_bound = cfg_range_addr;
            hi_bound = cfg_prim_addr;
        end
    end

    always_comb begin
        src_hit[0] = (addr_in == cfg_prim_addr);
        src_hit[1] = range_ok && (addr_in == cfg_range_addr);
        src_hit[2] = range_ok && (addr_in >= lo_bound) && (addr_in <= hi_bound);
        src_hit[3] = cfg_gc_en && (addr_in == AW'(GCALL_ADDR)) && !addr_rw;
        src_hit[4] = cfg_alt_en && (addr_in == cfg_alt_addr);
        src_hit[5] = cfg_alert_en && (addr_in == AW'(ALERT_ADDR));
    end

    assign hit       = |src_hit;
    assign range_hit = src_hit[1] | src_hit[2];

endmodule

// File: rtl/slv_session_fsm.sv
module slv_session_fsm
    import i2c_slv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_busy,
    input  logic addr_valid,
    input  logic hit,
    input  logic addr_rw,
    output logic slave_rw
);

    session_e state_q;
    session_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SES_IDLE, SES_WRITE, SES_READ: begin
                if (!bus_busy) begin
                    state_d = SES_IDLE;
                end else if (addr_valid) begin
                    if (!hit) begin
                        state_d = SES_IDLE;
                    end else if (addr_rw) begin
                        state_d = SES_READ;
                    end else begin
                        state_d = SES_WRITE;
                    end
                end
            end
            default: state_d = SES_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SES_READ: slave_rw = 1'b1;
            default:  slave_rw = 1'b0;
        endcase
    end

endmodule

// File: rtl/slv_host_regs.sv
module slv_host_regs
    import i2c_slv_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic [DW-1:0]      status_vec,
    input  logic [DW-1:0]      rx_data,
    output logic [DW-1:0]      host_rdata,
    output logic [DW-1:0]      tx_data,
    output logic [DW-1:0]      ctrl_q,
    output logic               ctrl_wr,
    output logic               data_rd,
    output logic               data_wr,
    output logic [DW-1:0]      w1c_mask
);

    logic stat_wr;

    always_comb begin
        ctrl_wr = host_sel && host_wr && (host_addr == REG_CTRL);
        stat_wr = host_sel && host_wr && (host_addr == REG_STAT);
        data_wr = host_sel && host_wr && (host_addr == REG_DATA);
        data_rd = host_sel && !host_wr && (host_addr == REG_DATA);
        w1c_mask = stat_wr ? host_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            tx_data <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= host_wdata;
            end
            if (data_wr) begin
                tx_data <= host_wdata;
            end
        end
    end

    always_comb begin
        unique case (host_addr)
            REG_CTRL: host_rdata = ctrl_q;
            REG_STAT: host_rdata = status_vec;
            REG_DATA: host_rdata = rx_data;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/slv_status_flags.sv
module slv_status_flags
    import i2c_slv_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ev,
    input  logic          range_ev,
    input  logic          byte_done,
    input  logic          arb_lost,
    input  logic          ctrl_wr,
    input  logic          tcf_clr,
    input  logic [DW-1:0] w1c_mask,
    output logic          tcf_q,
    output logic          iaas_q,
    output logic          arb_q,
    output logic          rng_q,
    output logic          int_q
);

    logic tcf_set;

    assign tcf_set = byte_done | addr_ev;

    // set has priority over clear in every flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcf_q  <= 1'b1;
            iaas_q <= 1'b0;
            arb_q  <= 1'b0;
            rng_q  <= 1'b0;
            int_q  <= 1'b0;
        end else begin
            if (tcf_set) begin
                tcf_q <= 1'b1;
            end else if (tcf_clr) begin
                tcf_q <= 1'b0;
            end

            if (addr_ev) begin
                iaas_q <= 1'b1;
            end else if (ctrl_wr) begin
                iaas_q <= 1'b0;
            end

            if (arb_lost) begin
                arb_q <= 1'b1;
            end else if (w1c_mask[SB_ARB]) begin
                arb_q <= 1'b0;
            end

            if (range_ev) begin
                rng_q <= 1'b1;
            end else if (w1c_mask[SB_RNG]) begin
                rng_q <= 1'b0;
            end

            if (tcf_set) begin
                int_q <= 1'b1;
            end else if (w1c_mask[SB_INT]) begin
                int_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status
    import i2c_slv_pkg::*;
#(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_valid,
    input  logic [AW-1:0]      addr_in,
    input  logic               addr_rw,
    input  logic               byte_done,
    input  logic               buf_access,
    input  logic               bus_busy,
    input  logic               arb_lost,
    input  logic               rx_nack,
    input  logic [DW-1:0]      rx_data,
    input  logic [AW-1:0]      cfg_prim_addr,
    input  logic [AW-1:0]      cfg_range_addr,
    input  logic               cfg_range_en,
    input  logic               cfg_gc_en,
    input  logic               cfg_alt_en,
    input  logic [AW-1:0]      cfg_alt_addr,
    input  logic               cfg_alert_en,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    output logic [DW-1:0]      tx_data,
    output logic               addressed,
    output logic               xfer_done,
    output logic               slave_rw,
    output logic               irq
);

    logic          hit;
    logic          range_hit;
    logic          addr_ev;
    logic          range_ev;
    logic [DW-1:0] ctrl_q;
    logic          ctrl_wr;
    logic          data_rd;
    logic          data_wr;
    logic [DW-1:0] w1c_mask;
    logic          tcf_clr;
    logic          tcf_q;
    logic          iaas_q;
    logic          arb_q;
    logic          rng_q;
    logic          int_q;
    logic          srw;
    logic [DW-1:0] status_vec;

    slv_addr_match #(.AW(AW)) u_match (
        .addr_in        (addr_in),
        .addr_rw        (addr_rw),
        .cfg_prim_addr  (cfg_prim_addr),
        .cfg_range_addr (cfg_range_addr),
        .cfg_range_en   (cfg_range_en),
        .cfg_gc_en      (cfg_gc_en),
        .cfg_alt_en     (cfg_alt_en),
        .cfg_alt_addr   (cfg_alt_addr),
        .cfg_alert_en   (cfg_alert_en),
        .hit            (hit),
        .range_hit      (range_hit)
    );

    assign addr_ev  = addr_valid & hit;
    assign range_ev = addr_valid & range_hit;

    slv_session_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_busy   (bus_busy),
        .addr_valid (addr_valid),
        .hit        (hit),
        .addr_rw    (addr_rw),
        .slave_rw   (srw)
    );

    slv_host_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .status_vec (status_vec),
        .rx_data    (rx_data),
        .host_rdata (host_rdata),
        .tx_data    (tx_data),
        .ctrl_q     (ctrl_q),
        .ctrl_wr    (ctrl_wr),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .w1c_mask   (w1c_mask)
    );

    assign tcf_clr = (ctrl_q[CB_BUF] & buf_access)
                   | (!ctrl_q[CB_TX] & data_rd)
                   | (ctrl_q[CB_TX] & data_wr);

    slv_status_flags #(.DW(DW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_ev   (addr_ev),
        .range_ev  (range_ev),
        .byte_done (byte_done),
        .arb_lost  (arb_lost),
        .ctrl_wr   (ctrl_wr),
        .tcf_clr   (tcf_clr),
        .w1c_mask  (w1c_mask),
        .tcf_q     (tcf_q),
        .iaas_q    (iaas_q),
        .arb_q     (arb_q),
        .rng_q     (rng_q),
        .int_q     (int_q)
    );

    always_comb begin
        status_vec          = '0;
        status_vec[SB_TCF]  = tcf_q;
        status_vec[SB_ADDR] = iaas_q;
        status_vec[SB_BUSY] = bus_busy;
        status_vec[SB_ARB]  = arb_q;
        status_vec[SB_RNG]  = rng_q;
        status_vec[SB_SRW]  = srw;
        status_vec[SB_INT]  = int_q;
        status_vec[SB_NACK] = rx_nack;
    end

    assign addressed = iaas_q;
    assign xfer_done = tcf_q;
    assign slave_rw  = srw;
    assign irq       = int_q;

endmodule

// File: rtl/i2c_slv_checker.sv
module i2c_slv_checker
    import i2c_slv_pkg::*;
#(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               addr_valid,
    input logic [AW-1:0]      addr_in,
    input logic [AW-1:0]      cfg_prim_addr,
    input logic               byte_done,
    input logic               buf_access,
    input logic               bus_busy,
    input logic               arb_lost,
    input logic               host_sel,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [DW-1:0]      host_wdata,
    input logic               ctrl_buf,
    input logic               arb_flag,
    input logic               addressed,
    input logic               xfer_done,
    input logic               slave_rw,
    input logic               irq
);

    AST_PRIM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_in == cfg_prim_addr) |=> (addressed && xfer_done && irq)); // R2

    AST_CTRL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr && host_addr == REG_CTRL && !addr_valid) |=> !addressed); // R8

    AST_BYTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (xfer_done && irq)); // R9

    AST_BUF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_access && ctrl_buf && !addr_valid && !byte_done) |=> !xfer_done); // R10

    AST_ARB_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr && host_addr == REG_STAT && host_wdata[SB_ARB] && !arb_lost)
        |=> !arb_flag); // R11

    AST_IDLE_RW: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |=> !slave_rw); // R12

endmodule

bind i2c_slv_status i2c_slv_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_valid    (addr_valid),
    .addr_in       (addr_in),
    .cfg_prim_addr (cfg_prim_addr),
    .byte_done     (byte_done),
    .buf_access    (buf_access),
    .bus_busy      (bus_busy),
    .arb_lost      (arb_lost),
    .host_sel      (host_sel),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .ctrl_buf      (ctrl_q[i2c_slv_pkg::CB_BUF]),
    .arb_flag      (arb_q),
    .addressed     (addressed),
    .xfer_done     (xfer_done),
    .slave_rw      (slave_rw),
    .irq           (irq)
);

// File: tb/test_i2c_slv_status.sv
module test_i2c_slv_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_valid = 1'b0;
    logic [6:0] addr_in = '0;
    logic       addr_rw = 1'b0;
    logic       byte_done = 1'b0;
    logic       buf_access = 1'b0;
    logic       bus_busy = 1'b0;
    logic       arb_lost = 1'b0;
    logic       rx_nack = 1'b0;
    logic [7:0] rx_data = 8'h3C;
    logic [6:0] cfg_prim_addr = '0;
    logic [6:0] cfg_range_addr = '0;
    logic       cfg_range_en = 1'b0;
    logic       cfg_gc_en = 1'b0;
    logic       cfg_alt_en = 1'b0;
    logic [6:0] cfg_alt_addr = '0;
    logic       cfg_alert_en = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] tx_data;
    logic       addressed;
    logic       xfer_done;
    logic       slave_rw;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_slv_status i_i2c_slv_status (
        .clk, .rst_n, .addr_valid, .addr_in, .addr_rw, .byte_done, .buf_access,
        .bus_busy, .arb_lost, .rx_nack, .rx_data, .cfg_prim_addr, .cfg_range_addr,
        .cfg_range_en, .cfg_gc_en, .cfg_alt_en, .cfg_alt_addr, .cfg_alert_en,
        .host_sel, .host_wr, .host_addr, .host_wdata, .host_rdata, .tx_data,
        .addressed, .xfer_done, .slave_rw, .irq
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw);
        @(negedge clk);
        addr_in = a; addr_rw = rw; addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] junk;
        host_write(2'd0, 8'h00);
        host_write(2'd1, 8'hFF);
        host_read(2'd2, junk);
    endtask

    function automatic bit in_win(input logic [6:0] a, input logic [6:0] p, input logic [6:0] r);
        int lo;
        int hi;
        lo = (p < r) ? int'(p) : int'(r);
        hi = (p < r) ? int'(r) : int'(p);
        return (int'(a) >= lo) && (int'(a) <= hi);
    endfunction

    task automatic sweep(input logic [6:0] p, input logic [6:0] r, input bit ren,
                         input bit gce, input bit ale, input logic [6:0] alt, input bit arte);
        logic [7:0] st;
        bit exp_hit;
        bit exp_rng;
        cfg_prim_addr = p; cfg_range_addr = r; cfg_range_en = ren; cfg_gc_en = gce;
        cfg_alt_en = ale; cfg_alt_addr = alt; cfg_alert_en = arte;
        for (int a = 0; a < 128; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                exp_rng = ren && (r != 0) && in_win(7'(a), p, r);
                exp_hit = (7'(a) == p) || exp_rng
                        || (gce && a == 0 && rw == 0)
                        || (ale && 7'(a) == alt)
                        || (arte && a == 12);
                clear_all();
                host_read(2'd1, st);
                // R8 R11: control write and W1C leave only busy plus slave rw state
                check((st & 8'hFB) == 8'h20, "R8/R11 clear before sweep step", st, 8'h20);
                send_addr(7'(a), rw[0]);
                // R2 R3 R4 R5 R6 R7: match per source
                check(addressed == exp_hit, "R3/R4/R5/R6/R7 addressed", addressed, exp_hit);
                check(xfer_done == exp_hit, "R2 xfer_done with match", xfer_done, exp_hit);
                check(irq == exp_hit, "R2 irq with match", irq, exp_hit);
                check(slave_rw == (exp_hit && rw == 1), "R12 slave_rw", slave_rw, exp_hit && rw == 1);
                host_read(2'd1, st);
                check(st[3] == exp_rng, "R4 range bit", st[3], exp_rng);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        host_read(2'd1, st);
        check(st == 8'h80, "R1 status reset", st, 8'h80);
        check(!addressed && !slave_rw && !irq, "R1 outputs reset", {addressed, slave_rw, irq}, 0);

        bus_busy = 1'b1;
        sweep(7'h3A, 7'h00, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0);
        sweep(7'h50, 7'h48, 1'b1, 1'b0, 1'b0, 7'h00, 1'b0);
        sweep(7'h10, 7'h14, 1'b1, 1'b1, 1'b0, 7'h00, 1'b0);
        sweep(7'h22, 7'h00, 1'b1, 1'b0, 1'b1, 7'h61, 1'b1);
        sweep(7'h70, 7'h7F, 1'b1, 1'b1, 1'b1, 7'h05, 1'b1);
        sweep(7'h33, 7'h33, 1'b1, 1'b0, 1'b0, 7'h00, 1'b0);
        sweep(7'h44, 7'h20, 1'b0, 1'b0, 1'b0, 7'h00, 1'b0);

        // R8 with a nonzero control value
        cfg_prim_addr = 7'h3A; cfg_range_en = 1'b0; cfg_gc_en = 1'b0;
        cfg_alt_en = 1'b0; cfg_alert_en = 1'b0;
        clear_all();
        send_addr(7'h3A, 1'b1);
        host_write(2'd0, 8'h47);
        check(!addressed, "R8 ctrl write 47 clears addressed", addressed, 0);
        check(slave_rw, "R12 slave_rw kept while busy", slave_rw, 1);
        @(negedge clk); bus_busy = 1'b0;
        @(negedge clk);
        check(!slave_rw, "R12 idle bus drops slave_rw", slave_rw, 0);
        bus_busy = 1'b1;

        // R9 in receive mode
        clear_all();
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
        check(xfer_done && irq, "R9 byte_done sets", {xfer_done, irq}, 3);
        host_write(2'd2, 8'h9D);
        check(xfer_done, "R9 data write in rx mode keeps", xfer_done, 1);
        check(tx_data == 8'h9D, "R9 tx data loaded", tx_data, 8'h9D);
        host_read(2'd2, st);
        check(st == 8'h3C, "R9 rx data read", st, 8'h3C);
        check(!xfer_done, "R9 data read in rx mode clears", xfer_done, 1'b0);

        // R9 in transmit mode
        host_write(2'd0, 8'h10);
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
        host_read(2'd2, st);
        check(xfer_done, "R9 data read in tx mode keeps", xfer_done, 1);
        host_write(2'd2, 8'h61);
        check(!xfer_done, "R9 data write in tx mode clears", xfer_done, 0);

        // R10 buffered mode
        host_write(2'd0, 8'h00);
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0; buf_access = 1'b1;
        @(negedge clk); buf_access = 1'b0;
        check(xfer_done, "R10 buf access ignored unbuffered", xfer_done, 1);
        host_write(2'd0, 8'h08);
        @(negedge clk); buf_access = 1'b1;
        @(negedge clk); buf_access = 1'b0;
        check(!xfer_done, "R10 buf access clears in buffered mode", xfer_done, 0);

        // R11 write-one-to-clear
        host_write(2'd0, 8'h00);
        @(negedge clk); arb_lost = 1'b1;
        @(negedge clk); arb_lost = 1'b0;
        host_read(2'd1, st);
        check(st[4], "R11 arb lost sets bit4", st[4], 1);
        host_write(2'd1, 8'h00);
        host_read(2'd1, st);
        check(st[4] && st[1], "R11 writing zeros keeps flags", st[4:1], 4'b1001);
        host_write(2'd1, 8'h10);
        host_read(2'd1, st);
        check(!st[4] && st[1], "R11 W1C bit4 only", st[4:1], 4'b0001);
        host_write(2'd1, 8'h02);
        check(!irq, "R11 W1C bit1 drops irq", irq, 0);
        rx_nack = 1'b1;
        host_read(2'd1, st);
        check(st[0], "R1 nack bit position", st[0], 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule